// File: doc/BRIEF.md
# SDRAM CAS-Latency Data Path

This block carries the data side of a 16-bit synchronous DRAM port. A burst sequencer upstream issues one strobe per read beat and one per write beat. Read data from the array enters a delay chain on the read beat and leaves through a registered output a programmable number of clocks later: two clocks or three. Write beats pass straight through in the cycle they arrive, with a byte-enable pair for the array built from the two lane masks.

The same two-bit lane mask serves both directions, as on a real SDRAM pin pair. On a write it gates the bytes in that very cycle. On a read it acts two clocks after it is sampled, zeroing the masked byte of the read output and clearing that lane's valid bit. A burst-read/single-write mode lets reads run for the full burst but lets only the first beat of each write burst reach the array. The latency setting is taken from its input only when no read beat is in flight, so a change can never split a beat's delay. All inputs are sampled, and all registered outputs change, on the rising clock edge.

Top module: `sdr_cas_datapath`

## Requirements
- R1: While reset is asserted and on the first cycle after release, `dq_vld_o` is 0, `dq_lane_vld_o` is 2'b00, `dq_o` is 0 and `cl3_o` is 0 (latency two selected).
- R2: With `cl3_o` = 0, a read beat sampled at edge k puts its data on `dq_o` with `dq_vld_o` = 1 after edge k+1, for exactly one cycle per beat.
- R3: With `cl3_o` = 1, a read beat sampled at edge k appears on `dq_o` with `dq_vld_o` = 1 after edge k+2, for exactly one cycle per beat.
- R4: Read beats on consecutive edges emerge on consecutive cycles in issue order; a write beat or an idle cycle that ends a read burst early does not cancel beats already sampled.
- R5: A write beat that is accepted raises `arr_we_o` and copies `wr_data_i` to `arr_wdata_o` in the same cycle, with no register in the path.
- R6: On an accepted write, `arr_be_o[0]` (bits 7:0) is the inverse of `dqm_i[0]` and `arr_be_o[1]` (bits 15:8) is the inverse of `dqm_i[1]`; a masked byte has enable 0 so the stored byte is left unchanged.
- R7: With `single_wr_i` = 1, only a write beat with `wr_first_i` = 1 is accepted and every other write beat leaves `arr_we_o` at 0; with `single_wr_i` = 0 every write beat is accepted.
- R8: A lane mask bit sampled at edge m applies to the read output loaded at edge m+1: that lane's byte of `dq_o` reads 0 and its bit of `dq_lane_vld_o` is 0, while `dq_vld_o` still marks the beat.
- R9: `cl3_o` follows `cl3_i` (1 selects latency three) only at an edge where no read beat is sampled and no beat is waiting in the delay chain; otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cl3_i | input | 1 | Requested latency: 0 for two clocks, 1 for three |
| single_wr_i | input | 1 | Burst-read/single-write mode |
| rd_beat_i | input | 1 | Read beat strobe from the burst sequencer |
| rd_data_i | input | 16 | Array read data for the current read beat |
| wr_beat_i | input | 1 | Write beat strobe from the burst sequencer |
| wr_first_i | input | 1 | Marks the first beat of a write burst |
| wr_data_i | input | 16 | Write data for the current write beat |
| dqm_i | input | 2 | Lane masks, bit 0 for bits 7:0, bit 1 for bits 15:8 |
| arr_we_o | output | 1 | Write enable to the array |
| arr_be_o | output | 2 | Byte enables to the array |
| arr_wdata_o | output | 16 | Write data to the array |
| dq_o | output | 16 | Registered read data |
| dq_vld_o | output | 1 | Read beat present on `dq_o` |
| dq_lane_vld_o | output | 2 | Per-lane read valid after masking |
| cl3_o | output | 1 | Latency currently in force |

## Verification
The lane mask is shared, so a write beat with a mask can land while read beats are still travelling down the chain, and the same mask value then gates the write at once and a read two clocks later. The bench provokes this by ending a two-beat read burst at latency three with a masked write: it judges the write enables in the write cycle, the first read beat emerging unmasked in the cycle after, and the second beat emerging with only the masked byte zeroed. A second overlap, a latency request arriving while a beat is in flight, is judged by when `cl3_o` moves and by the beat still keeping its old delay.

// File: rtl/sdr_dp_pkg.sv
package sdr_dp_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned CL_MIN = 2;
  localparam int unsigned CL_MAX = 3;
  // Registers in front of the output stage at the longest latency.
  localparam int unsigned STAGES = CL_MAX - 1;
  localparam int unsigned IDX_W  = (STAGES > 1) ? $clog2(STAGES) : 1;
endpackage

// File: rtl/sdr_dp_rst_sync.sv
module sdr_dp_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/sdr_dp_lat_ctrl.sv
module sdr_dp_lat_ctrl #(
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cl3_i,
  input  logic              rd_beat_i,
  input  logic [STAGES-1:0] stage_vld_i,
  output logic              cl3_o
);
  logic busy;
  logic cl3_d;
  logic cl3_q;

  always_comb begin
    busy  = rd_beat_i | (|stage_vld_i);
    cl3_d = busy ? cl3_q : cl3_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cl3_q <= 1'b0;
    end else begin
      cl3_q <= cl3_d;
    end
  end

  assign cl3_o = cl3_q;
endmodule

// File: rtl/sdr_dp_rd_pipe.sv
module sdr_dp_rd_pipe
  import sdr_dp_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cl3_i,
  input  logic              rd_beat_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [LANES-1:0]  dqm_i,
  output logic [STAGES-1:0] stage_vld_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_vld_o,
  output logic [LANES-1:0]  dq_lane_vld_o
);
  localparam logic [IDX_W-1:0] LONG_TAP = IDX_W'(CL_MAX - CL_MIN);

  logic [STAGES-1:0]             vld_q;
  logic [STAGES-1:0]             vld_d;
  logic [STAGES-1:0]             stage_en;
  logic [STAGES-1:0][DATA_W-1:0] data_q;
  logic [STAGES-1:0][DATA_W-1:0] data_d;
  logic [IDX_W-1:0]              tap_idx;
  logic                          tap_vld;
  logic [DATA_W-1:0]             tap_data;
  logic [LANES-1:0]              mask_q;
  logic [LANES-1:0]              lane_vld_d;
  logic [DATA_W-1:0]             dq_d;
  logic                          dq_vld_q;
  logic [LANES-1:0]              lane_vld_q;
  logic [DATA_W-1:0]             dq_q;

  // Chain next state: shift in the new beat, stages past the tap stay empty.
  always_comb begin
    tap_idx = cl3_i ? LONG_TAP : '0;
    for (int i = 0; i < int'(STAGES); i++) begin
      stage_en[i] = (int'(tap_idx) >= i);
    end
    vld_d  = {vld_q[STAGES-2:0], rd_beat_i} & stage_en;
    data_d = {data_q[STAGES-2:0], rd_data_i};
    tap_vld  = vld_q[tap_idx];
    tap_data = data_q[tap_idx];
  end

  // Output next state: lane masks sampled one edge earlier.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      lane_vld_d[l]           = tap_vld & ~mask_q[l];
      dq_d[l*LANE_W +: LANE_W] = lane_vld_d[l] ? tap_data[l*LANE_W +: LANE_W] : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q      <= '0;
      data_q     <= '0;
      mask_q     <= '0;
      dq_vld_q   <= 1'b0;
      lane_vld_q <= '0;
      dq_q       <= '0;
    end else begin
      vld_q  <= vld_d;
      for (int i = 0; i < int'(STAGES); i++) begin
        if (vld_d[i]) begin
          data_q[i] <= data_d[i];
        end
      end
      mask_q     <= dqm_i;
      dq_vld_q   <= tap_vld;
      lane_vld_q <= lane_vld_d;
      dq_q       <= dq_d;
    end
  end

  assign stage_vld_o   = vld_q;
  assign dq_o          = dq_q;
  assign dq_vld_o      = dq_vld_q;
  assign dq_lane_vld_o = lane_vld_q;
endmodule

// File: rtl/sdr_dp_wr_gate.sv
module sdr_dp_wr_gate #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              single_wr_i,
  input  logic              wr_beat_i,
  input  logic              wr_first_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [LANES-1:0]  dqm_i,
  output logic              arr_we_o,
  output logic [LANES-1:0]  arr_be_o,
  output logic [DATA_W-1:0] arr_wdata_o
);
  logic accept;

  always_comb begin
    accept      = wr_beat_i & (~single_wr_i | wr_first_i);
    arr_we_o    = accept;
    arr_be_o    = accept ? ~dqm_i : '0;
    arr_wdata_o = wr_data_i;
  end
endmodule

// File: rtl/sdr_cas_datapath.sv
module sdr_cas_datapath
  import sdr_dp_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cl3_i,
  input  logic              single_wr_i,
  input  logic              rd_beat_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              wr_beat_i,
  input  logic              wr_first_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [LANES-1:0]  dqm_i,
  output logic              arr_we_o,
  output logic [LANES-1:0]  arr_be_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_vld_o,
  output logic [LANES-1:0]  dq_lane_vld_o,
  output logic              cl3_o
);
  logic              rst_n_sync;
  logic [STAGES-1:0] stage_vld;

  sdr_dp_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  sdr_dp_lat_ctrl #(.STAGES(STAGES)) u_lat (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_sync),
    .cl3_i       (cl3_i),
    .rd_beat_i   (rd_beat_i),
    .stage_vld_i (stage_vld),
    .cl3_o       (cl3_o)
  );

  sdr_dp_rd_pipe #(.DATA_W(DATA_W), .LANES(LANES)) u_rd (
    .clk_i         (clk_i),
    .rst_ni        (rst_n_sync),
    .cl3_i         (cl3_o),
    .rd_beat_i     (rd_beat_i),
    .rd_data_i     (rd_data_i),
    .dqm_i         (dqm_i),
    .stage_vld_o   (stage_vld),
    .dq_o          (dq_o),
    .dq_vld_o      (dq_vld_o),
    .dq_lane_vld_o (dq_lane_vld_o)
  );

  sdr_dp_wr_gate #(.DATA_W(DATA_W), .LANES(LANES)) u_wr (
    .single_wr_i (single_wr_i),
    .wr_beat_i   (wr_beat_i),
    .wr_first_i  (wr_first_i),
    .wr_data_i   (wr_data_i),
    .dqm_i       (dqm_i),
    .arr_we_o    (arr_we_o),
    .arr_be_o    (arr_be_o),
    .arr_wdata_o (arr_wdata_o)
  );
endmodule

// File: rtl/sdr_cas_datapath_chk.sv
module sdr_cas_datapath_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              single_wr_i,
  input logic              rd_beat_i,
  input logic              wr_beat_i,
  input logic              wr_first_i,
  input logic [LANES-1:0]  dqm_i,
  input logic              arr_we_o,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_vld_o,
  input logic [LANES-1:0]  dq_lane_vld_o,
  input logic              cl3_o
);
  p_lat_two_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_beat_i && !cl3_o) |-> ##2 dq_vld_o);

  p_lat_three_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_beat_i && cl3_o) |-> ##3 dq_vld_o);

  p_no_orphan_two_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_vld_o && !cl3_o) |-> $past(rd_beat_i, 2));

  p_no_orphan_three_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_vld_o && cl3_o) |-> $past(rd_beat_i, 3));

  p_single_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_wr_i && wr_beat_i && !wr_first_i) |-> !arr_we_o);

  p_we_needs_beat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> wr_beat_i);

  p_mask_lo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_vld_o && $past(dqm_i[0], 2)) |-> (!dq_lane_vld_o[0] && dq_o[7:0] == 8'h00));

  p_mask_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_vld_o && $past(dqm_i[LANES-1], 2)) |->
      (!dq_lane_vld_o[LANES-1] && dq_o[DATA_W-1 -: 8] == 8'h00));

  p_lane_implies_beat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_lane_vld_o != '0) |-> dq_vld_o);

  p_cl_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_beat_i |=> $stable(cl3_o));
endmodule

bind sdr_cas_datapath sdr_cas_datapath_chk #(.DATA_W(DATA_W), .LANES(LANES)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .single_wr_i   (single_wr_i),
  .rd_beat_i     (rd_beat_i),
  .wr_beat_i     (wr_beat_i),
  .wr_first_i    (wr_first_i),
  .dqm_i         (dqm_i),
  .arr_we_o      (arr_we_o),
  .dq_o          (dq_o),
  .dq_vld_o      (dq_vld_o),
  .dq_lane_vld_o (dq_lane_vld_o),
  .cl3_o         (cl3_o)
);

// File: tb/sdr_cas_datapath_tb_top.sv
`timescale 1ns/1ps
module sdr_cas_datapath_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cl3_i;
  logic        single_wr_i;
  logic        rd_beat_i;
  logic [15:0] rd_data_i;
  logic        wr_beat_i;
  logic        wr_first_i;
  logic [15:0] wr_data_i;
  logic [1:0]  dqm_i;
  logic        arr_we_o;
  logic [1:0]  arr_be_o;
  logic [15:0] arr_wdata_o;
  logic [15:0] dq_o;
  logic        dq_vld_o;
  logic [1:0]  dq_lane_vld_o;
  logic        cl3_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  sdr_cas_datapath dut_i (
    .clk_i, .rst_ni, .cl3_i, .single_wr_i, .rd_beat_i, .rd_data_i,
    .wr_beat_i, .wr_first_i, .wr_data_i, .dqm_i, .arr_we_o, .arr_be_o,
    .arr_wdata_o, .dq_o, .dq_vld_o, .dq_lane_vld_o, .cl3_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    rd_beat_i = 1'b0; wr_beat_i = 1'b0; wr_first_i = 1'b0; dqm_i = 2'b00;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; cl3_i = 1'b0; single_wr_i = 1'b0; rd_data_i = '0; wr_data_i = '0;
    idle();
    repeat (3) tick();
    chk("R1 vld in reset", {31'b0, dq_vld_o}, 32'd0);
    chk("R1 lanes in reset", {30'b0, dq_lane_vld_o}, 32'd0);
    rst_ni = 1'b1;
    tick();
    chk("R1 data after release", {16'b0, dq_o}, 32'd0);
    chk("R1 latency two", {31'b0, cl3_o}, 32'd0);
    repeat (3) tick();
  endtask

  task automatic t_cl2_read();
    rd_beat_i = 1'b1; rd_data_i = 16'hA55A;
    tick();                       // edge k
    idle();
    chk("R2 not yet after k", {31'b0, dq_vld_o}, 32'd0);
    tick();                       // edge k+1
    chk("R2 vld after k+1", {31'b0, dq_vld_o}, 32'd1);
    chk("R2 data", {16'b0, dq_o}, 32'h0000A55A);
    chk("R2 lanes", {30'b0, dq_lane_vld_o}, 32'd3);
    tick();
    chk("R2 one cycle", {31'b0, dq_vld_o}, 32'd0);
  endtask

  task automatic t_to_cl3();
    cl3_i = 1'b1;
    tick();
    chk("R9 taken when idle", {31'b0, cl3_o}, 32'd1);
    tick();
  endtask

  task automatic t_cl3_read();
    rd_beat_i = 1'b1; rd_data_i = 16'h1234;
    tick();                       // edge k
    idle();
    tick();                       // edge k+1
    chk("R3 not yet after k+1", {31'b0, dq_vld_o}, 32'd0);
    tick();                       // edge k+2
    chk("R3 vld after k+2", {31'b0, dq_vld_o}, 32'd1);
    chk("R3 data", {16'b0, dq_o}, 32'h00001234);
    tick();
    chk("R3 one cycle", {31'b0, dq_vld_o}, 32'd0);
  endtask

  // Two-beat read at latency three cut short by a masked write.
  task automatic t_read_cut_by_write();
    rd_beat_i = 1'b1; rd_data_i = 16'hB0B0;
    tick();                       // edge k
    rd_data_i = 16'hC1C2;
    tick();                       // edge k+1
    rd_beat_i = 1'b0; wr_beat_i = 1'b1; wr_first_i = 1'b1;
    wr_data_i = 16'hDEAD; dqm_i = 2'b01;
    #1;
    chk("R5 we same cycle", {31'b0, arr_we_o}, 32'd1);
    chk("R5 wdata same cycle", {16'b0, arr_wdata_o}, 32'h0000DEAD);
    chk("R6 low lane masked", {30'b0, arr_be_o}, 32'd2);
    tick();                       // edge k+2
    idle();
    chk("R4 first beat", {16'b0, dq_o}, 32'h0000B0B0);
    chk("R4 first beat lanes", {30'b0, dq_lane_vld_o}, 32'd3);
    tick();                       // edge k+3
    chk("R4 second beat vld", {31'b0, dq_vld_o}, 32'd1);
    chk("R8 low byte zeroed", {16'b0, dq_o}, 32'h0000C100);
    chk("R8 low lane invalid", {30'b0, dq_lane_vld_o}, 32'd2);
    tick();
    chk("R4 burst ends", {31'b0, dq_vld_o}, 32'd0);
  endtask

  task automatic t_write_masks();
    wr_beat_i = 1'b1; wr_first_i = 1'b1; wr_data_i = 16'h0F0F;
    dqm_i = 2'b00; #1;
    chk("R6 no mask", {30'b0, arr_be_o}, 32'd3);
    dqm_i = 2'b10; #1;
    chk("R6 high lane masked", {30'b0, arr_be_o}, 32'd1);
    dqm_i = 2'b11; #1;
    chk("R6 both masked", {30'b0, arr_be_o}, 32'd0);
    chk("R5 we with full mask", {31'b0, arr_we_o}, 32'd1);
    idle(); #1;
    chk("R5 no beat no we", {31'b0, arr_we_o}, 32'd0);
    tick();
  endtask

  task automatic t_single_write();
    single_wr_i = 1'b1;
    wr_beat_i = 1'b1; wr_first_i = 1'b1; #1;
    chk("R7 first beat accepted", {31'b0, arr_we_o}, 32'd1);
    tick();
    wr_first_i = 1'b0; #1;
    chk("R7 later beat dropped", {31'b0, arr_we_o}, 32'd0);
    chk("R7 dropped beat no enables", {30'b0, arr_be_o}, 32'd0);
    tick();
    single_wr_i = 1'b0; #1;
    chk("R7 normal mode later beat", {31'b0, arr_we_o}, 32'd1);
    tick();
    idle();
  endtask

  // Request latency two while a latency-three beat is in flight.
  task automatic t_cl_change_busy();
    cl3_i = 1'b0;
    rd_beat_i = 1'b1; rd_data_i = 16'h5EED;
    tick();                       // edge k
    idle();
    chk("R9 held on beat edge", {31'b0, cl3_o}, 32'd1);
    tick();                       // edge k+1
    chk("R9 held while in chain", {31'b0, cl3_o}, 32'd1);
    tick();                       // edge k+2
    chk("R9 held at last stage", {31'b0, cl3_o}, 32'd1);
    chk("R3 old latency kept", {16'b0, dq_o}, 32'h00005EED);
    tick();                       // edge k+3
    chk("R9 taken when empty", {31'b0, cl3_o}, 32'd0);
    tick();
    rd_beat_i = 1'b1; rd_data_i = 16'h7788; dqm_i = 2'b10;
    tick();                       // edge j
    idle();
    tick();                       // edge j+1
    chk("R2 new latency", {31'b0, dq_vld_o}, 32'd1);
    chk("R8 high byte zeroed", {16'b0, dq_o}, 32'h00000088);
    tick();
  endtask

  initial begin
    t_reset();
    t_cl2_read();
    t_to_cl3();
    t_cl3_read();
    t_read_cut_by_write();
    t_write_masks();
    t_single_write();
    t_cl_change_busy();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule